// File: doc/BRIEF.md
# 8-bit ALU with Carry and Zero Flags

This block is the arithmetic and logic unit of a small 8-bit datapath. The surrounding control logic sets two operands and a four-bit operation code. The unit then computes the result in the same cycle. It also reports whether that result should be written back, and gives the next values of the carry flag (C) and the zero flag (Z). Only the two flags are held in registers inside the block. When the flag-update enable is high on a rising clock edge, those registers load the next-flag values. The current carry feeds the carry-in paths: add with carry, subtract with borrow, and the two shifts.

The flag rules are not uniform across operations. Among the logic operations, only compare changes C. Test changes only Z and writes nothing. The shifts pass their bits through C. Set-carry and clear-carry both force Z to 1. For subtraction, compare and decrement, C means that a borrow occurred.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both flag registers read 0 whatever `op` and `flag_en` are.
- R2: Add (op=0) and add-with-carry (op=1) give result = (A + B [+ C]) mod 256 with the write-enable high. Next C is the carry out of bit 7, and next Z is 1 exactly when the 8-bit result is zero.
- R3: Subtract (op=2) and subtract-with-borrow (op=3) give result = (A − B [− C]) mod 256 with the write-enable high. Next C is 1 exactly when A < B (+C), and next Z follows the 8-bit result.
- R4: AND (op=4) and OR (op=5) write the bitwise result. Next Z is 1 exactly when that result is zero, and next C equals the current C.
- R5: Test (op=6) keeps the write-enable low. Next Z is 1 exactly when A AND B is zero, and next C equals the current C.
- R6: Compare (op=7) keeps the write-enable low. It gives C=1, Z=0 for A < B, C=0, Z=1 for A = B, and C=0, Z=0 for A > B.
- R7: Shift-left (op=8) writes {A[6:0], C} and moves A[7] into next C. Next Z follows the result. For example, 0x12 with C=1 gives 0x25, and 0x80 with C=0 gives 0x00 with C=1.
- R8: Shift-right (op=9) writes {C, A[7:1]} and moves A[0] into next C. Next Z follows the result. For example, 0x12 with C=1 gives 0x89, and 0x01 with C=0 gives 0x00 with C=1.
- R9: Nibble swap (op=10) writes {A[3:0], A[7:4]}, for example 0xAB to 0xBA, and leaves both flags as they are.
- R10: Increment (op=11) and decrement (op=12) write (A ± 1) mod 256. Next C is the carry out for increment and the borrow for decrement, and next Z follows the result.
- R11: Set-carry (op=13) gives next C=1, Z=1, and clear-carry (op=14) gives next C=0, Z=1. Neither writes a result.
- R12: When `flag_en` is low, a clock edge leaves both flag registers unchanged. When it is high, the registers take the values that `c_next` and `z_next` showed before the edge.
- R13: The idle code (op=15) writes nothing and passes both current flags to the next-flag outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag registers |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 4 | Operation code (see requirements) |
| flag_en | input | 1 | Load next flags into the flag registers at the edge |
| opa | input | 8 | First operand (A) |
| opb | input | 8 | Second operand (B) |
| result | output | 8 | Combinational result; meaningful only when `res_we` is high |
| res_we | output | 1 | Result should be written back |
| c_next | output | 1 | Carry value the operation produces |
| z_next | output | 1 | Zero value the operation produces |
| c_flag | output | 1 | Registered carry flag |
| z_flag | output | 1 | Registered zero flag |

## Verification
The assertions check these on every cycle: the hold and load rules of the flag registers, reset clearing, the write-enable being suppressed for test, compare, set/clear-carry and idle, and C being passed through for AND, OR, test and swap. They also check the compare flag table, the increment carry, and Z agreeing with the result for every op that writes. The exact result values only show up in the bench's sweeps: carry-in into add and subtract, the bit arrangement of the shifts, and the swap. The sweeps run every op over all A values, a spread of B values and all four flag states. Directed sequences add a two-byte add chained through the registered carry, and the worked shift examples.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_TST  = 4'd6,
    OP_CMP  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_SWP  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_SETC = 4'd13,
    OP_CLRC = 4'd14,
    OP_IDLE = 4'd15
  } alu_op_e;

  localparam int OP_BITS = 4;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cflag
);

  localparam int FW = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic             ci;
  logic             is_sub;
  logic [FW-1:0]    full;

  // One adder serves every arithmetic op: subtraction uses the inverted
  // operand and carry-in, and the carry out is inverted to give a borrow.
  always_comb begin
    b_eff  = b;
    ci     = 1'b0;
    is_sub = 1'b0;
    case (op)
      OP_ADD: begin b_eff = b;  ci = 1'b0; end
      OP_ADC: begin b_eff = b;  ci = cin;  end
      OP_SUB, OP_CMP: begin
        b_eff = ~b; ci = 1'b1; is_sub = 1'b1;
      end
      OP_SBC: begin b_eff = ~b; ci = ~cin; is_sub = 1'b1; end
      OP_INC: begin b_eff = '0; ci = 1'b1; end
      OP_DEC: begin b_eff = '1; ci = 1'b0; is_sub = 1'b1; end
      default: begin b_eff = b; ci = 1'b0; end
    endcase
  end

  assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, ci};
  assign sum   = full[WIDTH-1:0];
  assign cflag = full[WIDTH] ^ is_sub;

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (op)
      OP_OR:   res = a | b;
      default: res = a & b;
    endcase
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  generate
    if (WIDTH % 2 == 0) begin : g_even
      assign swapped = {a[HALF-1:0], a[WIDTH-1:HALF]};
    end else begin : g_odd
      assign swapped = a;
    end
  endgenerate

  always_comb begin
    case (op)
      OP_SHL: begin
        res  = {a[WIDTH-2:0], cin};
        cout = a[WIDTH-1];
      end
      OP_SHR: begin
        res  = {cin, a[WIDTH-1:1]};
        cout = a[0];
      end
      default: begin
        res  = swapped;
        cout = cin;
      end
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic c_d,
  input  logic z_d,
  output logic c_q,
  output logic z_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (en) begin
      c_q <= c_d;
      z_q <= z_d;
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic             flag_en,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             res_we,
  output logic             c_next,
  output logic             z_next,
  output logic             c_flag,
  output logic             z_flag
);

  alu_op_e          op_e;
  logic [WIDTH-1:0] ar_sum;
  logic             ar_c;
  logic [WIDTH-1:0] lg_res;
  logic [WIDTH-1:0] sh_res;
  logic             sh_c;

  assign op_e = alu_op_e'(op);

  alu8_arith #(.WIDTH(WIDTH)) arith_i (
    .op(op_e), .a(opa), .b(opb), .cin(c_flag), .sum(ar_sum), .cflag(ar_c)
  );

  alu8_logic #(.WIDTH(WIDTH)) logic_i (
    .op(op_e), .a(opa), .b(opb), .res(lg_res)
  );

  alu8_shift #(.WIDTH(WIDTH)) shift_i (
    .op(op_e), .a(opa), .cin(c_flag), .res(sh_res), .cout(sh_c)
  );

  always_comb begin
    result = opa;
    res_we = 1'b0;
    c_next = c_flag;
    z_next = z_flag;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        result = ar_sum;
        res_we = 1'b1;
        c_next = ar_c;
        z_next = ~|ar_sum;
      end
      OP_AND, OP_OR: begin
        result = lg_res;
        res_we = 1'b1;
        z_next = ~|lg_res;
      end
      OP_TST: begin
        result = lg_res;
        z_next = ~|lg_res;
      end
      OP_CMP: begin
        result = ar_sum;
        c_next = ar_c;
        z_next = ~|ar_sum;
      end
      OP_SHL, OP_SHR: begin
        result = sh_res;
        res_we = 1'b1;
        c_next = sh_c;
        z_next = ~|sh_res;
      end
      OP_SWP: begin
        result = sh_res;
        res_we = 1'b1;
      end
      OP_SETC: begin
        c_next = 1'b1;
        z_next = 1'b1;
      end
      OP_CLRC: begin
        c_next = 1'b0;
        z_next = 1'b1;
      end
      OP_IDLE: begin
        res_we = 1'b0;
      end
      default: begin
        res_we = 1'b0;
      end
    endcase
  end

  alu8_flags flags_i (
    .clk(clk), .rst(rst), .en(flag_en),
    .c_d(c_next), .z_d(z_next), .c_q(c_flag), .z_q(z_flag)
  );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op,
  input logic             flag_en,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] result,
  input logic             res_we,
  input logic             c_next,
  input logic             z_next,
  input logic             c_flag,
  input logic             z_flag
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!c_flag && !z_flag));

  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> ($stable(c_flag) && $stable(z_flag)));

  assert_flags_load_R12: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> (c_flag == $past(c_next) && z_flag == $past(z_next)));

  assert_logic_keeps_c_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND || op == OP_OR) |-> (res_we && c_next == c_flag));

  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TST) |-> (!res_we && c_next == c_flag && z_next == ((opa & opb) == '0)));

  assert_compare_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |-> (!res_we && c_next == (opa < opb) && z_next == (opa == opb)));

  assert_swap_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SWP) |-> (res_we && c_next == c_flag && z_next == z_flag));

  assert_inc_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC) |-> ({c_next, result} == ({1'b0, opa} + {{WIDTH{1'b0}}, 1'b1})));

  assert_setclr_R11: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SETC || op == OP_CLRC) |-> (!res_we && z_next && c_next == (op == OP_SETC)));

  assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
    (op == OP_IDLE) |-> (!res_we && c_next == c_flag && z_next == z_flag));

  assert_zero_tracks_result_R2: assert property (@(posedge clk) disable iff (rst)
    (res_we && op != OP_SWP) |-> (z_next == (result == '0)));

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .op(op), .flag_en(flag_en), .opa(opa), .opb(opb),
  .result(result), .res_we(res_we), .c_next(c_next), .z_next(z_next),
  .c_flag(c_flag), .z_flag(z_flag)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd15;
  logic       flag_en = 1'b0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [7:0] result;
  logic       res_we, c_next, z_next, c_flag, z_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_core #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .op(op), .flag_en(flag_en), .opa(opa), .opb(opb),
    .result(result), .res_we(res_we), .c_next(c_next), .z_next(z_next),
    .c_flag(c_flag), .z_flag(z_flag)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1:   return "R2";
      2, 3:   return "R3";
      4, 5:   return "R4";
      6:      return "R5";
      7:      return "R6";
      8:      return "R7";
      9:      return "R8";
      10:     return "R9";
      11, 12: return "R10";
      13, 14: return "R11";
      default: return "R13";
    endcase
  endfunction

  // Reference model: returns {we, c, z, result[7:0]}
  function automatic logic [10:0] model(int o, int a, int b, int c, int z);
    int  r = a;
    bit  we = 0;
    bit  cn = c[0];
    bit  zn = z[0];
    bit  upd_z = 0;
    case (o)
      0:  begin r = a + b;     we = 1; cn = (r > 255); upd_z = 1; end
      1:  begin r = a + b + c; we = 1; cn = (r > 255); upd_z = 1; end
      2:  begin r = a - b;     we = 1; cn = (r < 0);   upd_z = 1; end
      3:  begin r = a - b - c; we = 1; cn = (r < 0);   upd_z = 1; end
      4:  begin r = a & b;     we = 1; upd_z = 1; end
      5:  begin r = a | b;     we = 1; upd_z = 1; end
      6:  begin r = a & b;     upd_z = 1; end
      7:  begin r = a - b;     cn = (a < b); upd_z = 1; end
      8:  begin r = ((a * 2) % 256) + c; cn = (a >= 128); we = 1; upd_z = 1; end
      9:  begin r = (c * 128) + (a / 2); cn = (a % 2 == 1); we = 1; upd_z = 1; end
      10: begin r = ((a % 16) * 16) + (a / 16); we = 1; end
      11: begin r = a + 1; cn = (r > 255); we = 1; upd_z = 1; end
      12: begin r = a - 1; cn = (r < 0);   we = 1; upd_z = 1; end
      13: begin cn = 1; zn = 1; end
      14: begin cn = 0; zn = 1; end
      default: ;
    endcase
    r = ((r % 256) + 256) % 256;
    if (upd_z) zn = (r == 0);
    return {we, cn, zn, r[7:0]};
  endfunction

  task automatic check_bit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic check_byte(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // One combinational vector against the model, flags held (flag_en low)
  task automatic vec(int o, int a, int b, int c, int z);
    logic [10:0] e;
    bit ok;
    op = 4'(o); opa = 8'(a); opb = 8'(b);
    #1;
    e = model(o, a, b, c, z);
    ok = (res_we === e[10]) && (c_next === e[9]) && (z_next === e[8]) &&
         (!e[10] || result === e[7:0]) && (c_flag === 1'(c)) && (z_flag === 1'(z));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h C=%0d Z=%0d: actual we=%0b r=%02h c=%0b z=%0b flags=%0b%0b expected we=%0b r=%02h c=%0b z=%0b flags=%0d%0d (R12 for flags)",
               tag_of(o), o, a, b, c, z, res_we, result, c_next, z_next, c_flag, z_flag,
               e[10], e[7:0], e[9], e[8], c, z);
    end
  endtask

  // Apply one op at a falling edge with flag_en, let one rising edge pass
  task automatic step(int o, int a, int b, bit en);
    @(negedge clk);
    op = 4'(o); opa = 8'(a); opb = 8'(b); flag_en = en;
    @(posedge clk);
    #2;
  endtask

  task automatic set_state(int c, int z);
    if (c == 0 && z == 0) step(0, 1, 0, 1'b1);
    else if (c == 1 && z == 0) step(0, 255, 2, 1'b1);
    else if (c == 1) step(13, 0, 0, 1'b1);
    else step(14, 0, 0, 1'b1);
    @(negedge clk);
    flag_en = 1'b0;
    op = 4'd15;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds flags at zero even with a set-carry request
    op = 4'd13; flag_en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check_bit("R1", "c_flag in reset", c_flag, 1'b0);
    check_bit("R1", "z_flag in reset", z_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0; flag_en = 1'b0; op = 4'd15;
    @(posedge clk); #2;
    check_bit("R1", "c_flag after reset", c_flag, 1'b0);
    check_bit("R1", "z_flag after reset", z_flag, 1'b0);

    // Sweep: every op, all A, spread of B, all four flag states (R2..R13, R12 hold)
    for (int s = 0; s < 4; s++) begin
      int cs = s / 2;
      int zs = s % 2;
      set_state(cs, zs);
      for (int o = 0; o < 16; o++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b += 9) begin
            vec(o, a, b, cs, zs);
            if (b == 252) vec(o, a, 255, cs, zs);
          end
    end

    // R7 worked examples through the flag register
    step(13, 0, 0, 1'b1);
    @(negedge clk); op = 4'd8; opa = 8'h12; flag_en = 1'b0; #1;
    check_byte("R7", "shl 12 C=1", result, 8'h25);
    check_bit("R7", "shl 12 carry out", c_next, 1'b0);
    step(14, 0, 0, 1'b1);
    step(8, 8'h80, 0, 1'b1);
    check_bit("R7", "shl 80 C registered", c_flag, 1'b1);
    check_bit("R7", "shl 80 Z registered", z_flag, 1'b1);

    // R8 worked examples
    step(13, 0, 0, 1'b1);
    @(negedge clk); op = 4'd9; opa = 8'h12; flag_en = 1'b0; #1;
    check_byte("R8", "shr 12 C=1", result, 8'h89);
    step(14, 0, 0, 1'b1);
    step(9, 8'h01, 0, 1'b1);
    check_bit("R8", "shr 01 C registered", c_flag, 1'b1);
    check_bit("R8", "shr 01 Z registered", z_flag, 1'b1);

    // R2: 16-bit add 12FF + 0101 chained through the registered carry
    step(0, 8'hFF, 8'h01, 1'b1);
    check_bit("R2", "low byte carry", c_flag, 1'b1);
    @(negedge clk); op = 4'd1; opa = 8'h12; opb = 8'h01; flag_en = 1'b0; #1;
    check_byte("R2", "high byte with carry", result, 8'h14);

    // R3: borrow chain 1200 - 0001 = 11FF
    step(2, 8'h00, 8'h01, 1'b1);
    check_bit("R3", "low byte borrow", c_flag, 1'b1);
    @(negedge clk); op = 4'd3; opa = 8'h12; opb = 8'h00; flag_en = 1'b0; #1;
    check_byte("R3", "high byte with borrow", result, 8'h11);

    // R12: flag_en low keeps flags across an op that would change them
    step(14, 0, 0, 1'b1);
    step(0, 8'hFF, 8'h01, 1'b0);
    check_bit("R12", "C held", c_flag, 1'b0);
    check_bit("R12", "Z held", z_flag, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule